// File: doc/BRIEF.md
# Parameter-Block Disk Command Sequencer

This block runs one floppy-disk command per start pulse. When started, it latches the address of a seven-byte command block held in system memory. It fetches that block as a byte-wide bus master and selects one of four drives. It then judges the request against the drive's ready, density and write-protect inputs. A request that passes is carried out: a block of 128-byte sectors is copied between the memory buffer and a byte-addressed sector store, or one track of the store is filled, or the drive's head position is updated.

The outcome appears on a two-bit result type and an eight-bit error byte, and a completion interrupt is raised. A host writes the command block into memory, pulses start with the block's address, and waits for the interrupt. The interrupt stays set until the next accepted start. Media timing, CRC generation and deleted-data marks are not modelled.

Top module: `pblk_disk_seq`

## Requirements
- R1: After reset, busy and irq are 0, rtype is 2'b10, rerr is 8'h00, mem_req and st_we are 0, and every drive's recorded track and sector are 0.
- R2: A start seen while busy is 0 latches pb_addr, sets busy and clears irq on the next edge. The block then reads seven bytes from pb_addr upward: +0 channel word (unused), +1 instruction, +2 record count, +3 track, +4 sector, +5 buffer address low byte, +6 buffer address high byte.
- R3: mem_req stays high with mem_addr, mem_we and mem_wdata unchanged until mem_ack is seen. Any number of wait states is accepted, and read data is taken from mem_rdata in the ack cycle.
- R4: Instruction bits 5:4 select the drive. If that drive's drv_ready bit is 0, the command ends with rtype 2'b00 and rerr 8'h80, whatever else is wrong with it.
- R5: Instruction bits 2:0 give the opcode: 0 nop, 1 seek, 2 format, 3 recalibrate, 4 read, 5 verify, 6 write, 7 write-deleted. The command ends with rtype 2'b00 and rerr 8'h08 if sector is 0, sector exceeds the sectors per track, sector plus count exceeds the sectors per track plus 1, or track exceeds 76. The sectors per track is 52 when the drive's drv_dd bit is 1 and 26 otherwise. Recalibrate skips this check.
- R6: Format and write on a drive whose drv_wp bit is 1 end with rtype 2'b00 and rerr 8'h20 and leave the store untouched. Other opcodes ignore drv_wp, and an address error outranks write protect.
- R7: Write copies count sectors from memory to the store. Store address is {drive, offset}, with offset = (track × sectors per track + sector − 1) × 128 + byte. After each sector the sector number rises by 1 and the buffer address by 0x80.
- R8: Read copies count sectors from the store to memory using the same addressing, and writes no memory byte past count × 128 from the buffer address.
- R9: Format reads one fill byte at the buffer address and writes it to every byte of the addressed track, from track × sectors per track × 128 for sectors per track × 128 bytes, and to no other store byte.
- R10: Seek records the block's track and sector for the selected drive on drv_trk/drv_sec (drive d at bits 8d+7:8d). Recalibrate records track 0 and the block's sector. Other drives keep their values.
- R11: Nop, verify and write-deleted that pass the checks end with rtype 2'b10 and rerr 8'h00, with no transfer. So do every other successful command.
- R12: At completion, busy falls and irq rises on the same edge, with rtype and rerr already holding the result. irq then holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; honoured only when idle |
| pb_addr | input | 16 | Memory address of the command block |
| drv_ready | input | 4 | Per-drive ready |
| drv_dd | input | 4 | Per-drive density: 1 = 52 sectors, 0 = 26 sectors |
| drv_wp | input | 4 | Per-drive write protect |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per access |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| st_we | output | 1 | Sector-store write strobe |
| st_addr | output | 21 | Sector-store byte address {drive, offset} |
| st_wdata | output | 8 | Sector-store write data |
| st_rdata | input | 8 | Sector-store read data for st_addr |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Completion interrupt |
| rtype | output | 2 | Result type: 2'b00 error, 2'b10 success |
| rerr | output | 8 | Error byte: 8'h80 not ready, 8'h08 address, 8'h20 write protect |
| drv_trk | output | 32 | Recorded track per drive |
| drv_sec | output | 32 | Recorded sector per drive |

## Verification
Readiness, address limits and write protect are all judged on the same cycle, so one command block can fail several of them at once. The table holds blocks that combine faults: an unready drive with sector 0, and a protected drive given a write with sector 0. The error byte must show only the highest-ranked cause, and a checker requires exactly one error bit whenever the type is 2'b00. The table also sends a read to a protected drive, which must succeed.

// File: rtl/pblk_pkg.sv
package pblk_pkg;

    localparam int BYTE_W     = 8;
    localparam int SECT_BYTES = 128;
    localparam int SECT_SH    = 7;
    localparam int LAST_TRK   = 76;
    localparam int DD_SPT     = 52;
    localparam int SD_SPT     = 26;
    localparam int PB_LEN     = 7;
    localparam int PB_IDX_W   = $clog2(PB_LEN);
    localparam int IDX_W      = 13;   // enough for one whole double-density track

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SEEK   = 3'd1,
        OP_FMT    = 3'd2,
        OP_RECAL  = 3'd3,
        OP_READ   = 3'd4,
        OP_VERIFY = 3'd5,
        OP_WRITE  = 3'd6,
        OP_WDEL   = 3'd7
    } op_e;

    localparam logic [1:0] RT_ERR = 2'b00;
    localparam logic [1:0] RT_OK  = 2'b10;

    localparam logic [7:0] ERR_NRDY = 8'h80;
    localparam logic [7:0] ERR_ADDR = 8'h08;
    localparam logic [7:0] ERR_WP   = 8'h20;

    typedef struct packed {
        logic [7:0]  chan;
        logic [7:0]  instr;
        logic [7:0]  count;
        logic [7:0]  trk;
        logic [7:0]  sec;
        logic [15:0] buf_a;
    } pblk_t;

    typedef struct packed {
        logic       fail;
        logic [7:0] code;
    } verdict_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_FILL,
        S_FMT,
        S_RD_LOAD,
        S_RD_MEM,
        S_WR_MEM,
        S_WR_ST,
        S_DONE
    } seq_state_e;

    function automatic logic [7:0] spt_of(input logic dd);
        return dd ? 8'(DD_SPT) : 8'(SD_SPT);
    endfunction

endpackage

// File: rtl/pblk_check.sv
module pblk_check
    import pblk_pkg::*;
(
    input  pblk_t    pb,
    input  logic     ready,
    input  logic     dd,
    input  logic     wp,
    output verdict_t verdict
);
    op_e        op;
    logic [7:0] spt;
    logic [8:0] span;
    logic       addr_bad;
    logic       wp_bad;

    always_comb begin
        op       = op_e'(pb.instr[2:0]);
        spt      = spt_of(dd);
        span     = {1'b0, pb.sec} + {1'b0, pb.count};
        addr_bad = (op != OP_RECAL) &&
                   ((pb.sec == 8'd0) ||
                    (pb.sec > spt) ||
                    (span > ({1'b0, spt} + 9'd1)) ||
                    (pb.trk > 8'(LAST_TRK)));
        wp_bad   = wp && ((op == OP_FMT) || (op == OP_WRITE));

        verdict = '0;
        if (!ready) begin
            verdict.fail = 1'b1;
            verdict.code = ERR_NRDY;
        end else if (addr_bad) begin
            verdict.fail = 1'b1;
            verdict.code = ERR_ADDR;
        end else if (wp_bad) begin
            verdict.fail = 1'b1;
            verdict.code = ERR_WP;
        end
    end
endmodule

// File: rtl/pblk_offset.sv
module pblk_offset
    import pblk_pkg::*;
#(
    parameter int OFF_W = 19
) (
    input  logic [7:0]       trk,
    input  logic [7:0]       sec,
    input  logic             dd,
    input  logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] off
);
    localparam int CALC_W = 24;

    logic [CALC_W-1:0] lin;
    logic [CALC_W-1:0] full;

    always_comb begin
        lin  = CALC_W'(trk) * CALC_W'(spt_of(dd)) + CALC_W'(sec) - CALC_W'(1);
        full = (lin << SECT_SH) + CALC_W'(idx);
        off  = OFF_W'(full);
    end
endmodule

// File: rtl/pblk_pos.sv
module pblk_pos #(
    parameter int N_DRV = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld,
    input  logic [$clog2(N_DRV)-1:0] sel,
    input  logic [7:0]               trk_in,
    input  logic [7:0]               sec_in,
    output logic [N_DRV*8-1:0]       trk_out,
    output logic [N_DRV*8-1:0]       sec_out
);
    for (genvar d = 0; d < N_DRV; d++) begin : g_drv
        logic [7:0] trk_q;
        logic [7:0] sec_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                trk_q <= '0;
                sec_q <= '0;
            end else if (ld && (int'(sel) == d)) begin
                trk_q <= trk_in;
                sec_q <= sec_in;
            end
        end

        assign trk_out[d*8 +: 8] = trk_q;
        assign sec_out[d*8 +: 8] = sec_q;
    end
endmodule

// File: rtl/pblk_disk_seq.sv
module pblk_disk_seq
    import pblk_pkg::*;
#(
    parameter int N_DRV  = 4,
    parameter int MEM_AW = 16,
    parameter int OFF_W  = 19
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [MEM_AW-1:0]                pb_addr,
    input  logic [N_DRV-1:0]                 drv_ready,
    input  logic [N_DRV-1:0]                 drv_dd,
    input  logic [N_DRV-1:0]                 drv_wp,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [MEM_AW-1:0]                mem_addr,
    output logic [7:0]                       mem_wdata,
    input  logic                             mem_ack,
    input  logic [7:0]                       mem_rdata,
    output logic                             st_we,
    output logic [$clog2(N_DRV)+OFF_W-1:0]   st_addr,
    output logic [7:0]                       st_wdata,
    input  logic [7:0]                       st_rdata,
    output logic                             busy,
    output logic                             irq,
    output logic [1:0]                       rtype,
    output logic [7:0]                       rerr,
    output logic [N_DRV*8-1:0]               drv_trk,
    output logic [N_DRV*8-1:0]               drv_sec
);
    localparam int DRV_W = $clog2(N_DRV);
    localparam logic [IDX_W-1:0] SECT_LAST = IDX_W'(SECT_BYTES - 1);

    seq_state_e          state;
    pblk_t               pb;
    logic [MEM_AW-1:0]   pb_base;
    logic [PB_IDX_W-1:0] fidx;
    logic [7:0]          cur_sec;
    logic [MEM_AW-1:0]   cur_buf;
    logic [7:0]          remain;
    logic [IDX_W-1:0]    bidx;
    logic [7:0]          data_q;
    logic                busy_q;
    logic                irq_q;
    logic [1:0]          rtype_q;
    logic [7:0]          rerr_q;

    logic [DRV_W-1:0]    drv;
    op_e                 op;
    verdict_t            verdict;
    logic [OFF_W-1:0]    off;
    logic [7:0]          off_sec;
    logic [IDX_W-1:0]    fmt_last;
    logic                sect_end;
    logic                pos_ld;
    logic [7:0]          pos_trk;

    assign drv      = pb.instr[4 +: DRV_W];
    assign op       = op_e'(pb.instr[2:0]);
    assign fmt_last = IDX_W'(spt_of(drv_dd[drv])) * IDX_W'(SECT_BYTES) - IDX_W'(1);
    assign sect_end = (bidx == SECT_LAST);
    assign off_sec  = (state == S_FMT) ? 8'd1 : cur_sec;

    pblk_check u_check (
        .pb      (pb),
        .ready   (drv_ready[drv]),
        .dd      (drv_dd[drv]),
        .wp      (drv_wp[drv]),
        .verdict (verdict)
    );

    pblk_offset #(.OFF_W(OFF_W)) u_offset (
        .trk (pb.trk),
        .sec (off_sec),
        .dd  (drv_dd[drv]),
        .idx (bidx),
        .off (off)
    );

    always_comb begin
        pos_ld  = (state == S_CHECK) && !verdict.fail &&
                  ((op == OP_SEEK) || (op == OP_RECAL));
        pos_trk = (op == OP_RECAL) ? 8'd0 : pb.trk;
    end

    pblk_pos #(.N_DRV(N_DRV)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .ld      (pos_ld),
        .sel     (drv),
        .trk_in  (pos_trk),
        .sec_in  (pb.sec),
        .trk_out (drv_trk),
        .sec_out (drv_sec)
    );

    // memory and store port drive, decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_q;
        st_we     = 1'b0;
        st_addr   = {drv, off};
        st_wdata  = data_q;
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = pb_base + MEM_AW'(fidx);
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = cur_buf;
            end
            S_RD_MEM: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_buf + MEM_AW'(bidx[SECT_SH-1:0]);
            end
            S_WR_MEM: begin
                mem_req  = 1'b1;
                mem_addr = cur_buf + MEM_AW'(bidx[SECT_SH-1:0]);
            end
            S_WR_ST, S_FMT: st_we = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            pb      <= '0;
            pb_base <= '0;
            fidx    <= '0;
            cur_sec <= '0;
            cur_buf <= '0;
            remain  <= '0;
            bidx    <= '0;
            data_q  <= '0;
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
            rtype_q <= RT_OK;
            rerr_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        pb_base <= pb_addr;
                        fidx    <= '0;
                        busy_q  <= 1'b1;
                        irq_q   <= 1'b0;
                        state   <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        unique case (fidx)
                            3'd0: pb.chan        <= mem_rdata;
                            3'd1: pb.instr       <= mem_rdata;
                            3'd2: pb.count       <= mem_rdata;
                            3'd3: pb.trk         <= mem_rdata;
                            3'd4: pb.sec         <= mem_rdata;
                            3'd5: pb.buf_a[7:0]  <= mem_rdata;
                            default: pb.buf_a[15:8] <= mem_rdata;
                        endcase
                        if (fidx == PB_IDX_W'(PB_LEN - 1)) state <= S_CHECK;
                        else fidx <= fidx + 1'b1;
                    end
                end
                S_CHECK: begin
                    cur_sec <= pb.sec;
                    cur_buf <= MEM_AW'(pb.buf_a);
                    remain  <= pb.count;
                    bidx    <= '0;
                    if (verdict.fail) begin
                        rtype_q <= RT_ERR;
                        rerr_q  <= verdict.code;
                        state   <= S_DONE;
                    end else begin
                        rtype_q <= RT_OK;
                        rerr_q  <= '0;
                        unique case (op)
                            OP_FMT:   state <= S_FILL;
                            OP_READ:  state <= (pb.count == 8'd0) ? S_DONE : S_RD_LOAD;
                            OP_WRITE: state <= (pb.count == 8'd0) ? S_DONE : S_WR_MEM;
                            default:  state <= S_DONE;
                        endcase
                    end
                end
                S_FILL: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        bidx   <= '0;
                        state  <= S_FMT;
                    end
                end
                S_FMT: begin
                    if (bidx == fmt_last) state <= S_DONE;
                    else bidx <= bidx + 1'b1;
                end
                S_RD_LOAD: begin
                    data_q <= st_rdata;
                    state  <= S_RD_MEM;
                end
                S_RD_MEM: begin
                    if (mem_ack) begin
                        if (sect_end) begin
                            bidx    <= '0;
                            cur_sec <= cur_sec + 8'd1;
                            cur_buf <= cur_buf + MEM_AW'(SECT_BYTES);
                            remain  <= remain - 8'd1;
                            state   <= (remain == 8'd1) ? S_DONE : S_RD_LOAD;
                        end else begin
                            bidx  <= bidx + 1'b1;
                            state <= S_RD_LOAD;
                        end
                    end
                end
                S_WR_MEM: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= S_WR_ST;
                    end
                end
                S_WR_ST: begin
                    if (sect_end) begin
                        bidx    <= '0;
                        cur_sec <= cur_sec + 8'd1;
                        cur_buf <= cur_buf + MEM_AW'(SECT_BYTES);
                        remain  <= remain - 8'd1;
                        state   <= (remain == 8'd1) ? S_DONE : S_WR_MEM;
                    end else begin
                        bidx  <= bidx + 1'b1;
                        state <= S_WR_MEM;
                    end
                end
                S_DONE: begin
                    busy_q <= 1'b0;
                    irq_q  <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy  = busy_q;
    assign irq   = irq_q;
    assign rtype = rtype_q;
    assign rerr  = rerr_q;

endmodule

// File: rtl/pblk_seq_chk.sv
module pblk_seq_chk #(
    parameter int N_DRV  = 4,
    parameter int MEM_AW = 16,
    parameter int OFF_W  = 19
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           start,
    input logic                           busy,
    input logic                           irq,
    input logic [1:0]                     rtype,
    input logic [7:0]                     rerr,
    input logic                           mem_req,
    input logic                           mem_we,
    input logic [MEM_AW-1:0]              mem_addr,
    input logic [7:0]                     mem_wdata,
    input logic                           mem_ack,
    input logic                           st_we,
    input logic [$clog2(N_DRV)+OFF_W-1:0] st_addr,
    input logic [N_DRV-1:0]               drv_wp
);
    localparam int DRV_W = $clog2(N_DRV);
    localparam int ST_AW = DRV_W + OFF_W;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))) // R3
        else $error("request dropped or changed before ack");

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)) // R2
        else $error("busy rose without start");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !st_we)) // R2
        else $error("port activity while idle");

    AST_ONE_ERR_BIT: assert property (@(posedge clk) disable iff (rst)
        (!busy && rtype == 2'b00) |-> ($countones(rerr) == 1)) // R4
        else $error("error byte not a single cause");

    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (!busy && rtype == 2'b10) |-> (rerr == 8'h00)) // R11
        else $error("success with error bits");

    AST_NO_WP_WRITE: assert property (@(posedge clk) disable iff (rst)
        st_we |-> !drv_wp[st_addr[ST_AW-1 -: DRV_W]]) // R6
        else $error("store written on protected drive");

    AST_DONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $rose(irq)) // R12
        else $error("completion edge mismatch");

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy) // R12
        else $error("irq while busy");

endmodule

bind pblk_disk_seq pblk_seq_chk #(
    .N_DRV  (N_DRV),
    .MEM_AW (MEM_AW),
    .OFF_W  (OFF_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .irq       (irq),
    .rtype     (rtype),
    .rerr      (rerr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .st_we     (st_we),
    .st_addr   (st_addr),
    .drv_wp    (drv_wp)
);

// File: tb/sim_pblk_disk_seq.sv
module sim_pblk_disk_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] pb_addr;
    logic [3:0]  drv_ready;
    logic [3:0]  drv_dd;
    logic [3:0]  drv_wp;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack;
    logic [7:0]  mem_rdata;
    logic        st_we;
    logic [20:0] st_addr;
    logic [7:0]  st_wdata;
    logic [7:0]  st_rdata;
    logic        busy;
    logic        irq;
    logic [1:0]  rtype;
    logic [7:0]  rerr;
    logic [31:0] drv_trk;
    logic [31:0] drv_sec;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    pblk_disk_seq u0 (
        .clk(clk), .rst(rst), .start(start), .pb_addr(pb_addr),
        .drv_ready(drv_ready), .drv_dd(drv_dd), .drv_wp(drv_wp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .busy(busy), .irq(irq), .rtype(rtype), .rerr(rerr),
        .drv_trk(drv_trk), .drv_sec(drv_sec)
    );

    // ---------------- memory and store models ----------------
    logic [7:0] bmem [int];
    logic [7:0] smem [int];
    int         wcnt;
    int         wlim;

    function automatic logic [7:0] rd_b(int a);
        if (bmem.exists(a)) return bmem[a];
        return 8'h00;
    endfunction

    function automatic logic [7:0] rd_s(int a);
        if (smem.exists(a)) return smem[a];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= 8'h00;
            wcnt      <= 0;
            wlim      <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= wlim) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd_b(int'(mem_addr));
                wcnt      <= 0;
                wlim      <= (wlim + 1) % 4;   // rotating wait states
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (mem_req && mem_we && mem_ack) bmem[int'(mem_addr)] = mem_wdata;
        if (st_we) smem[int'(st_addr)] = st_wdata;
        st_rdata <= rd_s(int'(st_addr));
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int s_key(int drv, int off);
        return (drv << 19) | off;
    endfunction

    localparam int PB_BASE = 16'h0100;

    task automatic run_cmd(input logic [1:0] d, input logic [2:0] op, input logic [7:0] cnt,
                           input logic [7:0] trk, input logic [7:0] sec, input logic [15:0] ba);
        int n;
        bmem[PB_BASE]   = 8'h00;
        bmem[PB_BASE+1] = {2'b00, d, 1'b0, op};
        bmem[PB_BASE+2] = cnt;
        bmem[PB_BASE+3] = trk;
        bmem[PB_BASE+4] = sec;
        bmem[PB_BASE+5] = ba[7:0];
        bmem[PB_BASE+6] = ba[15:8];
        @(negedge clk);
        pb_addr = 16'(PB_BASE);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        chk("R12 irq cleared by start", {31'd0, irq}, 32'd0);
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R12 irq with busy low", {31'd0, irq}, 32'd1);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0] d;
        logic [2:0] op;
        logic [7:0] cnt;
        logic [7:0] trk;
        logic [7:0] sec;
        logic [1:0] rt;
        logic [7:0] err;
    } vec_t;

    // drives: ready 0111, density 0101 (0,2 = 52 spt), protect 0100
    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{2'd3, 3'd4, 8'd1, 8'd0,  8'd1,  2'b00, 8'h80},  // R4 not ready
        '{2'd3, 3'd4, 8'd1, 8'd0,  8'd0,  2'b00, 8'h80},  // R4 outranks address
        '{2'd0, 3'd4, 8'd1, 8'd5,  8'd0,  2'b00, 8'h08},  // R5 sector 0
        '{2'd0, 3'd4, 8'd1, 8'd5,  8'd53, 2'b00, 8'h08},  // R5 past 52
        '{2'd1, 3'd4, 8'd1, 8'd5,  8'd27, 2'b00, 8'h08},  // R5 past 26
        '{2'd1, 3'd4, 8'd8, 8'd5,  8'd20, 2'b00, 8'h08},  // R5 span 28
        '{2'd0, 3'd4, 8'd1, 8'd77, 8'd1,  2'b00, 8'h08},  // R5 track 77
        '{2'd0, 3'd0, 8'd1, 8'd3,  8'd0,  2'b00, 8'h08},  // R5 nop checked too
        '{2'd0, 3'd3, 8'd1, 8'd99, 8'd0,  2'b10, 8'h00},  // R5 recalibrate exempt
        '{2'd2, 3'd6, 8'd1, 8'd1,  8'd1,  2'b00, 8'h20},  // R6 write protected
        '{2'd2, 3'd2, 8'd1, 8'd1,  8'd1,  2'b00, 8'h20},  // R6 format protected
        '{2'd2, 3'd6, 8'd1, 8'd1,  8'd0,  2'b00, 8'h08},  // R6 address outranks
        '{2'd2, 3'd4, 8'd1, 8'd1,  8'd1,  2'b10, 8'h00},  // R6 read ignores protect
        '{2'd0, 3'd0, 8'd1, 8'd3,  8'd1,  2'b10, 8'h00},  // R11 nop
        '{2'd0, 3'd5, 8'd4, 8'd3,  8'd1,  2'b10, 8'h00},  // R11 verify
        '{2'd0, 3'd7, 8'd1, 8'd3,  8'd1,  2'b10, 8'h00},  // R11 write-deleted
        '{2'd1, 3'd4, 8'd1, 8'd5,  8'd26, 2'b10, 8'h00},  // R5 last sector ok
        '{2'd0, 3'd4, 8'd0, 8'd5,  8'd52, 2'b10, 8'h00},  // R5 zero count ok
        '{2'd1, 3'd4, 8'd2, 8'd5,  8'd25, 2'b10, 8'h00}   // R5 span 27 ok
    };

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R12 watchdog actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst       = 1'b1;
        start     = 1'b0;
        pb_addr   = 16'h0;
        drv_ready = 4'b0111;
        drv_dd    = 4'b0101;
        drv_wp    = 4'b0100;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rtype", {30'd0, rtype}, 32'd2);
        chk("R1 rerr", {24'd0, rerr}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 track d1", {24'd0, drv_trk[15:8]}, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            run_cmd(VEC[i].d, VEC[i].op, VEC[i].cnt, VEC[i].trk, VEC[i].sec, 16'h7000);
            chk($sformatf("vec %0d rtype", i), {30'd0, rtype}, {30'd0, VEC[i].rt});
            chk($sformatf("vec %0d rerr", i), {24'd0, rerr}, {24'd0, VEC[i].err});
        end

        // R7 write, drive 0 (52 spt), track 2, sectors 51..52, buffer 0x4000
        for (int i = 0; i < 256; i++) bmem[16'h4000 + i] = 8'(i ^ 8'h5A);
        run_cmd(2'd0, 3'd6, 8'd2, 8'd2, 8'd51, 16'h4000);
        chk("R7 rtype", {30'd0, rtype}, 32'd2);
        begin
            int base;
            base = (2 * 52 + 50) * 128;
            chk("R7 byte 0",   {24'd0, rd_s(s_key(0, base))},       {24'd0, 8'h5A});
            chk("R7 byte 127", {24'd0, rd_s(s_key(0, base + 127))}, {24'd0, 8'(127 ^ 8'h5A)});
            chk("R7 byte 128", {24'd0, rd_s(s_key(0, base + 128))}, {24'd0, 8'(128 ^ 8'h5A)});
            chk("R7 byte 255", {24'd0, rd_s(s_key(0, base + 255))}, {24'd0, 8'(255 ^ 8'h5A)});
            chk("R7 no spill", {31'd0, smem.exists(s_key(0, base + 256))}, 32'd0);
        end

        // R8 read, drive 1 (26 spt), track 3, sectors 25..26, buffer 0x5000
        begin
            int base;
            base = (3 * 26 + 24) * 128;
            for (int i = 0; i < 256; i++) smem[s_key(1, base + i)] = 8'(i * 3 + 1);
            bmem[16'h5100] = 8'hCC;
            run_cmd(2'd1, 3'd4, 8'd2, 8'd3, 8'd25, 16'h5000);
            chk("R8 rtype", {30'd0, rtype}, 32'd2);
            chk("R8 byte 0",   {24'd0, rd_b(16'h5000)}, {24'd0, 8'd1});
            chk("R8 byte 127", {24'd0, rd_b(16'h507F)}, {24'd0, 8'(127 * 3 + 1)});
            chk("R8 byte 128", {24'd0, rd_b(16'h5080)}, {24'd0, 8'(128 * 3 + 1)});
            chk("R8 byte 255", {24'd0, rd_b(16'h50FF)}, {24'd0, 8'(255 * 3 + 1)});
            chk("R8 no overrun", {24'd0, rd_b(16'h5100)}, {24'd0, 8'hCC});
        end

        // R9 format drive 0 track 10 with fill 0xE5
        begin
            int tb0;
            tb0 = 10 * 52 * 128;
            bmem[16'h6000] = 8'hE5;
            smem[s_key(0, tb0 + 52 * 128)] = 8'h77;
            smem[s_key(0, tb0 - 1)] = 8'h66;
            run_cmd(2'd0, 3'd2, 8'd1, 8'd10, 8'd1, 16'h6000);
            chk("R9 rtype", {30'd0, rtype}, 32'd2);
            chk("R9 first", {24'd0, rd_s(s_key(0, tb0))}, {24'd0, 8'hE5});
            chk("R9 middle", {24'd0, rd_s(s_key(0, tb0 + 3000))}, {24'd0, 8'hE5});
            chk("R9 last", {24'd0, rd_s(s_key(0, tb0 + 52 * 128 - 1))}, {24'd0, 8'hE5});
            chk("R9 next track kept", {24'd0, rd_s(s_key(0, tb0 + 52 * 128))}, {24'd0, 8'h77});
            chk("R9 prev track kept", {24'd0, rd_s(s_key(0, tb0 - 1))}, {24'd0, 8'h66});
        end

        // R10 seek and recalibrate on drive 1
        run_cmd(2'd1, 3'd1, 8'd1, 8'd40, 8'd7, 16'h7000);
        chk("R10 seek track", {24'd0, drv_trk[15:8]}, 32'd40);
        chk("R10 seek sector", {24'd0, drv_sec[15:8]}, 32'd7);
        chk("R10 other drive", {24'd0, drv_trk[7:0]}, 32'd0);
        run_cmd(2'd1, 3'd3, 8'd1, 8'd55, 8'd3, 16'h7000);
        chk("R10 recal track", {24'd0, drv_trk[15:8]}, 32'd0);
        chk("R10 recal sector", {24'd0, drv_sec[15:8]}, 32'd3);

        // R12 irq holds while idle with no start
        repeat (5) @(negedge clk);
        chk("R12 irq held", {31'd0, irq}, 32'd1);
        // R3 wait states: rotating ack delays were applied throughout the copies above
        chk("R3 bus idle after command", {31'd0, mem_req}, 32'd0);

        summary();
        $finish;
    end

endmodule